// File: doc/BRIEF.md
# Ingress Virtual Output Queue

This block buffers the transaction-layer packets received on a single ingress port of a switch and sorts them by the destination station they are headed for. Each accepted packet is written into a shared beat store made of 20-byte beats. One descriptor from a fixed pool records where the packet's beats sit, how many there are and which egress port inside the station the packet targets. Each destination station has its own queue of descriptors, so a station that is slow to drain does not hold up packets bound for the other one.

Packets come in one beat per cycle. The first beat carries a start marker, the packet's total byte length and a routing tag (a station bit plus a two-bit egress port). The last beat carries an end marker. The block admits a packet only when it can hold the whole packet: it needs a free descriptor and enough unreserved beats for the full length. It decides this while the start beat is still presented, and it refuses the packet by holding ready low. Beats are handed out from a linked free list, so the beats of one packet need not be adjacent. The pointer chain that links a packet's beats doubles as its beat list, and when the packet leaves, the whole chain is spliced back onto the free list in a single cycle.

Each station's dequeue port presents the packet at the head of that station's queue beat by beat, framed with start and end markers. A packet whose declared length exceeds the largest legal packet is swallowed and never queued, and it raises a sticky error flag.

Top module: `ingress_voq`

## Requirements
- R1: A packet of L bytes (1 to 276) takes ceil(L/20) beats and is returned as exactly that many beats. So 12 B and 20 B take one beat, 21 B takes two and 276 B takes fourteen.
- R2: A start beat is presented when inValid and inSop are high and no packet is open. For that beat, inReady is high only if a descriptor is free and the unreserved beat count is at least the packet's beat count. An accepted packet reserves its full beat count. A refused start beat changes no state.
- R3: At most NUM_ENTRIES (default 32) packets are held at once. entriesFull is high exactly when all of them are in use.
- R4: Packets bound for one station leave in arrival order. A station's deqValid is high in every cycle in which a complete packet for that station is held.
- R5: Dequeued beats come out in the order they were written. deqSop is high on the first beat and deqEop on the last. While deqValid is high and deqReady is low, the presented beat does not change.
- R6: A packet's descriptor and all of its beats are freed on the clock edge that takes its last beat. A start beat in the very next cycle can use them.
- R7: A start beat with a declared length above 276 bytes is accepted. It and the beats that follow it, up to and including the one carrying inEop, are discarded and nothing is queued. oversizeErr rises and stays high until reset.
- R8: After reset, no deqValid is high, entriesFull and oversizeErr are low, and inReady is high.
- R9: inStation (0 or 1) selects which dequeue port returns the packet. That port's deqPort field returns the two-bit inPort value given with the start beat.
- R10: With deqReady held high, a station returns one beat in every cycle, with no idle cycle inside a packet or between queued packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An ingress beat is presented |
| inReady | output | 1 | The presented beat is taken on this edge |
| inSop | input | 1 | First beat of a packet |
| inEop | input | 1 | Last beat of a packet |
| inData | input | BEAT_BYTES*8 | Beat payload |
| inLen | input | LEN_W | Packet byte length, valid with inSop |
| inStation | input | 1 | Destination station, valid with inSop |
| inPort | input | 2 | Egress port inside the station, valid with inSop |
| deqValid | output | 2 | Per station: a beat is presented |
| deqReady | input | 2 | Per station: consumer takes the beat |
| deqSop | output | 2 | Per station: first beat of a packet |
| deqEop | output | 2 | Per station: last beat of a packet |
| deqData | output | 2*BEAT_BYTES*8 | Per station beat payload, station 0 in the low half |
| deqPort | output | 4 | Per station egress port tag, station 0 in the low two bits |
| entriesFull | output | 1 | Every descriptor is in use |
| oversizeErr | output | 1 | Sticky: an over-length packet was dropped |

## Verification
The bench pushes admission to its edges. It shrinks the beat store to 48 beats so that three maximum-size packets leave six beats. At that point a seven-beat packet must be refused and a six-beat one accepted. A design that checks only the descriptor count, or that rounds the beat count down, would accept a packet it cannot hold and corrupt its free list. It also fills all 32 descriptors with one-beat packets and then drains and refills them. A design that leaked descriptors or beats on release would refuse the refill. Dequeue data is compared with an identity pattern carrying the packet and beat index, so a broken beat chain or a splice that loses or duplicates beats shows up as wrong or repeated data. Over-length packets, one-beat versus multi-beat framing, and back-to-back drains with deqReady held high catch designs that queue dropped packets, misplace deqEop or insert bubbles.

// File: rtl/voq_pkg.sv
package voq_pkg;

  // Two destination stations per ingress port; this fixes the number of
  // dequeue ports and the width of the station tag.
  localparam int STATIONS = 2;
  localparam int STA_W    = (STATIONS > 1) ? $clog2(STATIONS) : 1;

  // Strobes from the control half to the beat store.
  typedef struct packed {
    logic                wrBeat;    // write inData into the free-list head beat
    logic                linkPrev;  // point the open packet's previous beat at the new one
    logic [STATIONS-1:0] relChain;  // splice a departing packet's chain onto the free list
  } dpStrobe_t;

  typedef enum logic [1:0] {
    IN_IDLE  = 2'd0,
    IN_STORE = 2'd1,
    IN_DROP  = 2'd2
  } inState_t;

endpackage

// File: rtl/voq_beat_store.sv
module voq_beat_store
  import voq_pkg::*;
#(
  parameter int BEAT_W    = 160,
  parameter int NUM_BEATS = 1376
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  dpStrobe_t                          strobe,
  input  logic [BEAT_W-1:0]                  wrData,
  input  logic [$clog2(NUM_BEATS)-1:0]       prevBeat,
  input  logic [STATIONS-1:0][$clog2(NUM_BEATS)-1:0] relHead,
  input  logic [STATIONS-1:0][$clog2(NUM_BEATS)-1:0] relTail,
  input  logic [STATIONS-1:0][$clog2(NUM_BEATS)-1:0] rdAddr,
  output logic [$clog2(NUM_BEATS)-1:0]       allocBeat,
  output logic [STATIONS-1:0][BEAT_W-1:0]    rdData,
  output logic [STATIONS-1:0][$clog2(NUM_BEATS)-1:0] rdNext
);

  localparam int PTR_W = $clog2(NUM_BEATS);

  logic [BEAT_W-1:0] beatRam [NUM_BEATS];
  logic [PTR_W-1:0]  nextPtr [NUM_BEATS];
  logic [PTR_W-1:0]  freeHead;
  logic [PTR_W-1:0]  restHead;
  logic [PTR_W-1:0]  newHead;
  logic [STATIONS-1:0][PTR_W-1:0] linkTo;

  assign allocBeat = freeHead;

  // Free-list head after this cycle: pop one beat if writing, then push the
  // chains of any departing packets in front of what remains.
  always_comb begin
    restHead = strobe.wrBeat ? nextPtr[freeHead] : freeHead;
    newHead  = restHead;
    for (int s = STATIONS - 1; s >= 0; s--) begin
      linkTo[s] = newHead;
      if (strobe.relChain[s]) newHead = relHead[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BEATS; i++) nextPtr[i] <= PTR_W'(i + 1);
      freeHead <= '0;
    end else begin
      if (strobe.linkPrev) nextPtr[prevBeat] <= freeHead;
      for (int s = 0; s < STATIONS; s++) begin
        if (strobe.relChain[s]) nextPtr[relTail[s]] <= linkTo[s];
      end
      freeHead <= newHead;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrBeat) beatRam[freeHead] <= wrData;
  end

  for (genvar s = 0; s < STATIONS; s++) begin : g_rd
    assign rdData[s] = beatRam[rdAddr[s]];
    assign rdNext[s] = nextPtr[rdAddr[s]];
  end

  // R5: a chain link is only made together with the beat it points to.
  a_r5_link_with_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.linkPrev |-> strobe.wrBeat);

  // R6: two packets released together never share a tail beat.
  a_r6_distinct_tails: assert property (@(posedge clk) disable iff (!rstN)
    (&strobe.relChain) |-> (relTail[0] != relTail[STATIONS-1]));

endmodule

// File: rtl/voq_ctrl.sv
module voq_ctrl
  import voq_pkg::*;
#(
  parameter int BEAT_BYTES        = 20,
  parameter int NUM_BEATS         = 1376,
  parameter int NUM_ENTRIES       = 32,
  parameter int PORTS_PER_STATION = 4,
  parameter int MAX_PKT_BYTES     = 276,
  parameter int LEN_W             = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  output logic inReady,
  input  logic inSop,
  input  logic inEop,
  input  logic [LEN_W-1:0] inLen,
  input  logic [STA_W-1:0] inStation,
  input  logic [$clog2(PORTS_PER_STATION)-1:0] inPort,
  output logic [STATIONS-1:0] deqValid,
  input  logic [STATIONS-1:0] deqReady,
  output logic [STATIONS-1:0] deqSop,
  output logic [STATIONS-1:0] deqEop,
  output logic [STATIONS-1:0][$clog2(PORTS_PER_STATION)-1:0] deqPort,
  output logic entriesFull,
  output logic oversizeErr,
  output dpStrobe_t strobe,
  output logic [$clog2(NUM_BEATS)-1:0] prevBeat,
  output logic [STATIONS-1:0][$clog2(NUM_BEATS)-1:0] relHead,
  output logic [STATIONS-1:0][$clog2(NUM_BEATS)-1:0] relTail,
  output logic [STATIONS-1:0][$clog2(NUM_BEATS)-1:0] rdAddr,
  input  logic [$clog2(NUM_BEATS)-1:0] allocBeat,
  input  logic [STATIONS-1:0][$clog2(NUM_BEATS)-1:0] rdNext
);

  localparam int PTR_W     = $clog2(NUM_BEATS);
  localparam int ENT_W     = $clog2(NUM_ENTRIES);
  localparam int PORT_W    = $clog2(PORTS_PER_STATION);
  localparam int MAX_BEATS = (MAX_PKT_BYTES + BEAT_BYTES - 1) / BEAT_BYTES;
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);
  localparam int FREE_W    = $clog2(NUM_BEATS + 1);
  localparam int USED_W    = $clog2(NUM_ENTRIES + 1);

  // Descriptor table
  logic [PTR_W-1:0]  descHead [NUM_ENTRIES];
  logic [PTR_W-1:0]  descTail [NUM_ENTRIES];
  logic [CNT_W-1:0]  descCnt  [NUM_ENTRIES];
  logic [PORT_W-1:0] descPort [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] entryBusy;
  logic [USED_W-1:0] entriesUsed;
  logic [FREE_W-1:0] freeBeats;
  logic [ENT_W-1:0]  freeIdx;

  // Ingress state
  inState_t          inState;
  logic [ENT_W-1:0]  openEnt;
  logic [STA_W-1:0]  openStation;
  logic [CNT_W-1:0]  openNeed;
  logic [CNT_W-1:0]  written;
  logic [PTR_W-1:0]  prevBeatQ;

  // Ingress decode
  logic [LEN_W:0]    lenPlus;
  logic [LEN_W:0]    needWide;
  logic [CNT_W-1:0]  needBeats;
  logic              tooLong, fits, sopIdle, admit, dropStart, storeBeat, closeNow;
  logic [ENT_W-1:0]  closeEnt;
  logic [STA_W-1:0]  closeSta;
  logic [CNT_W-1:0]  closeCnt;
  logic [CNT_W-1:0]  closeNeed;
  logic [CNT_W-1:0]  refund;

  // Release bus from the stations
  logic [STATIONS-1:0]             relChain;
  logic [STATIONS-1:0][CNT_W-1:0]  relCnt;
  logic [STATIONS-1:0][ENT_W-1:0]  relEnt;
  logic [FREE_W-1:0]               relBeats;

  always_comb begin
    freeIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!entryBusy[i]) freeIdx = ENT_W'(i);
    end
  end

  always_comb begin
    lenPlus   = {1'b0, inLen} + (LEN_W+1)'(BEAT_BYTES - 1);
    needWide  = lenPlus / (LEN_W+1)'(BEAT_BYTES);
    if (needWide == '0) needWide = (LEN_W+1)'(1);
    needBeats = CNT_W'(needWide);
    tooLong   = inLen > LEN_W'(MAX_PKT_BYTES);
    fits      = (entriesUsed < USED_W'(NUM_ENTRIES)) && (int'(freeBeats) >= int'(needWide));
    sopIdle   = inValid && inSop && (inState == IN_IDLE);
    inReady   = (inState != IN_IDLE) || !(inValid && inSop) || tooLong || fits;
    admit     = sopIdle && !tooLong && fits;
    dropStart = sopIdle && tooLong;
    storeBeat = inValid && (inState == IN_STORE);
    closeNow  = (admit && (inEop || needBeats == CNT_W'(1)))
             || (storeBeat && (inEop || (written + CNT_W'(1)) == openNeed));
    closeEnt  = admit ? freeIdx   : openEnt;
    closeSta  = admit ? inStation : openStation;
    closeCnt  = admit ? CNT_W'(1) : written + CNT_W'(1);
    closeNeed = admit ? needBeats : openNeed;
    refund    = closeNeed - closeCnt;
  end

  always_comb begin
    strobe.wrBeat   = admit || storeBeat;
    strobe.linkPrev = storeBeat;
    strobe.relChain = relChain;
  end
  assign prevBeat = prevBeatQ;

  always_comb begin
    relBeats = '0;
    for (int s = 0; s < STATIONS; s++) begin
      if (relChain[s]) relBeats = relBeats + FREE_W'(relCnt[s]);
    end
  end

  // Ingress sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inState     <= IN_IDLE;
      openEnt     <= '0;
      openStation <= '0;
      openNeed    <= '0;
      written     <= '0;
      prevBeatQ   <= '0;
      oversizeErr <= 1'b0;
    end else begin
      case (inState)
        IN_IDLE: begin
          if (admit) begin
            openEnt     <= freeIdx;
            openStation <= inStation;
            openNeed    <= needBeats;
            written     <= CNT_W'(1);
            prevBeatQ   <= allocBeat;
            if (!closeNow) inState <= IN_STORE;
          end
          if (dropStart) begin
            oversizeErr <= 1'b1;
            if (!inEop) inState <= IN_DROP;
          end
        end
        IN_STORE: begin
          if (storeBeat) begin
            prevBeatQ <= allocBeat;
            written   <= written + CNT_W'(1);
            if (closeNow) inState <= IN_IDLE;
          end
        end
        IN_DROP: begin
          if (inValid && inEop) inState <= IN_IDLE;
        end
        default: inState <= IN_IDLE;
      endcase
    end
  end

  // Resource accounting: descriptors and unreserved beats
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryBusy   <= '0;
      entriesUsed <= '0;
      freeBeats   <= FREE_W'(NUM_BEATS);
    end else begin
      if (admit) entryBusy[freeIdx] <= 1'b1;
      for (int s = 0; s < STATIONS; s++) begin
        if (relChain[s]) entryBusy[relEnt[s]] <= 1'b0;
      end
      entriesUsed <= entriesUsed + USED_W'(admit) - USED_W'($countones(relChain));
      freeBeats   <= freeBeats
                   - (admit    ? FREE_W'(needBeats) : '0)
                   + (closeNow ? FREE_W'(refund)    : '0)
                   + relBeats;
    end
  end

  always_ff @(posedge clk) begin
    if (admit) begin
      descHead[freeIdx] <= allocBeat;
      descPort[freeIdx] <= inPort;
    end
    if (closeNow) begin
      descTail[closeEnt] <= allocBeat;
      descCnt[closeEnt]  <= closeCnt;
    end
  end

  assign entriesFull = (entriesUsed == USED_W'(NUM_ENTRIES));

  // Per-station descriptor queues and beat walkers
  for (genvar s = 0; s < STATIONS; s++) begin : g_sta
    logic [ENT_W-1:0]  qMem [NUM_ENTRIES];
    logic [ENT_W-1:0]  qWr, qRd;
    logic [USED_W-1:0] qCnt;
    logic              active;
    logic [PTR_W-1:0]  rdPtr;
    logic [CNT_W-1:0]  pos;
    logic [ENT_W-1:0]  headEnt;
    logic              push, take, lastBeat;

    assign headEnt     = qMem[qRd];
    assign push        = closeNow && (closeSta == STA_W'(s));
    assign deqValid[s] = (qCnt != '0);
    assign lastBeat    = (pos + CNT_W'(1)) == descCnt[headEnt];
    assign take        = deqValid[s] && deqReady[s];
    assign deqSop[s]   = !active;
    assign deqEop[s]   = lastBeat;
    assign deqPort[s]  = descPort[headEnt];
    assign rdAddr[s]   = active ? rdPtr : descHead[headEnt];
    assign relChain[s] = take && lastBeat;
    assign relHead[s]  = descHead[headEnt];
    assign relTail[s]  = descTail[headEnt];
    assign relCnt[s]   = descCnt[headEnt];
    assign relEnt[s]   = headEnt;

    always_ff @(posedge clk) begin
      if (push) qMem[qWr] <= closeEnt;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        qWr    <= '0;
        qRd    <= '0;
        qCnt   <= '0;
        active <= 1'b0;
        rdPtr  <= '0;
        pos    <= '0;
      end else begin
        if (push) qWr <= (qWr == ENT_W'(NUM_ENTRIES - 1)) ? '0 : qWr + ENT_W'(1);
        if (take) begin
          if (lastBeat) begin
            active <= 1'b0;
            pos    <= '0;
            qRd    <= (qRd == ENT_W'(NUM_ENTRIES - 1)) ? '0 : qRd + ENT_W'(1);
          end else begin
            active <= 1'b1;
            rdPtr  <= rdNext[s];
            pos    <= pos + CNT_W'(1);
          end
        end
        qCnt <= qCnt + USED_W'(push) - USED_W'(relChain[s]);
      end
    end

    // R4: a station queue never holds more descriptors than exist.
    a_r4_queue_bound: assert property (@(posedge clk) disable iff (!rstN)
      qCnt <= USED_W'(NUM_ENTRIES));

    // R5: a stalled beat stays put.
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
      (deqValid[s] && !deqReady[s]) |=> (deqValid[s] && $stable(rdAddr[s]) && $stable(deqSop[s])));
  end

  // R2: reservations never drive the unreserved beat count past the store size.
  a_r2_beats_bound: assert property (@(posedge clk) disable iff (!rstN)
    freeBeats <= FREE_W'(NUM_BEATS));

  // R3: descriptor usage stays within the pool.
  a_r3_entries_bound: assert property (@(posedge clk) disable iff (!rstN)
    entriesUsed <= USED_W'(NUM_ENTRIES));

  // R3: the used count tracks the busy bitmap.
  a_r3_count_matches: assert property (@(posedge clk) disable iff (!rstN)
    int'(entriesUsed) == $countones(entryBusy));

  // R7: the over-length flag is sticky.
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    oversizeErr |=> oversizeErr);

endmodule

// File: rtl/ingress_voq.sv
module ingress_voq
  import voq_pkg::*;
#(
  parameter int BEAT_BYTES        = 20,
  parameter int NUM_BEATS         = 1376,
  parameter int NUM_ENTRIES       = 32,
  parameter int PORTS_PER_STATION = 4,
  parameter int MAX_PKT_BYTES     = 276,
  parameter int LEN_W             = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  output logic inReady,
  input  logic inSop,
  input  logic inEop,
  input  logic [BEAT_BYTES*8-1:0] inData,
  input  logic [LEN_W-1:0] inLen,
  input  logic [STA_W-1:0] inStation,
  input  logic [$clog2(PORTS_PER_STATION)-1:0] inPort,
  output logic [STATIONS-1:0] deqValid,
  input  logic [STATIONS-1:0] deqReady,
  output logic [STATIONS-1:0] deqSop,
  output logic [STATIONS-1:0] deqEop,
  output logic [STATIONS*BEAT_BYTES*8-1:0] deqData,
  output logic [STATIONS*$clog2(PORTS_PER_STATION)-1:0] deqPort,
  output logic entriesFull,
  output logic oversizeErr
);

  localparam int BEAT_W = BEAT_BYTES * 8;
  localparam int PTR_W  = $clog2(NUM_BEATS);
  localparam int PORT_W = $clog2(PORTS_PER_STATION);

  dpStrobe_t strobe;
  logic [PTR_W-1:0] prevBeat, allocBeat;
  logic [STATIONS-1:0][PTR_W-1:0]  relHead, relTail, rdAddr, rdNext;
  logic [STATIONS-1:0][BEAT_W-1:0] rdData;
  logic [STATIONS-1:0][PORT_W-1:0] deqPortV;

  voq_ctrl #(
    .BEAT_BYTES(BEAT_BYTES), .NUM_BEATS(NUM_BEATS), .NUM_ENTRIES(NUM_ENTRIES),
    .PORTS_PER_STATION(PORTS_PER_STATION), .MAX_PKT_BYTES(MAX_PKT_BYTES), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inSop(inSop),
    .inEop(inEop), .inLen(inLen), .inStation(inStation), .inPort(inPort),
    .deqValid(deqValid), .deqReady(deqReady), .deqSop(deqSop), .deqEop(deqEop),
    .deqPort(deqPortV), .entriesFull(entriesFull), .oversizeErr(oversizeErr),
    .strobe(strobe), .prevBeat(prevBeat), .relHead(relHead), .relTail(relTail),
    .rdAddr(rdAddr), .allocBeat(allocBeat), .rdNext(rdNext)
  );

  voq_beat_store #(
    .BEAT_W(BEAT_W), .NUM_BEATS(NUM_BEATS)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(inData), .prevBeat(prevBeat),
    .relHead(relHead), .relTail(relTail), .rdAddr(rdAddr), .allocBeat(allocBeat),
    .rdData(rdData), .rdNext(rdNext)
  );

  for (genvar s = 0; s < STATIONS; s++) begin : g_out
    assign deqData[s*BEAT_W +: BEAT_W] = rdData[s];
    assign deqPort[s*PORT_W +: PORT_W] = deqPortV[s];
  end

endmodule

// File: tb/ingress_voq_bench.sv
module ingress_voq_bench;
  localparam int BB = 20, NB = 48, NE = 32, MAXB = 276, LW = 10;
  localparam int BW = BB * 8, PW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic [BW-1:0] inData = '0;
  logic [LW-1:0] inLen = '0;
  logic [0:0] inStation = '0;
  logic [PW-1:0] inPort = '0;
  logic [1:0] deqReady = '0;
  logic inReady, entriesFull, oversizeErr;
  logic [1:0] deqValid, deqSop, deqEop;
  logic [2*BW-1:0] deqData;
  logic [2*PW-1:0] deqPort;

  ingress_voq #(.BEAT_BYTES(BB), .NUM_BEATS(NB), .NUM_ENTRIES(NE),
    .PORTS_PER_STATION(4), .MAX_PKT_BYTES(MAXB), .LEN_W(LW)) u_ingress_voq (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inSop(inSop),
    .inEop(inEop), .inData(inData), .inLen(inLen), .inStation(inStation), .inPort(inPort),
    .deqValid(deqValid), .deqReady(deqReady), .deqSop(deqSop), .deqEop(deqEop),
    .deqData(deqData), .deqPort(deqPort), .entriesFull(entriesFull), .oversizeErr(oversizeErr));

  int errors = 0, checks = 0;
  int modelBeats = NB, modelEntries = 0, nextId = 1;
  int expId[2][$];
  int expBeats[2][$];
  int expPort[2][$];

  function automatic int needFor(int len);
    return (len + BB - 1) / BB;
  endfunction

  function automatic logic [BW-1:0] beatVal(int id, int idx);
    return {5{id[15:0], idx[7:0], 8'hA5}};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic sendPkt(int len, int st, int port);
    int nb = needFor(len);
    bit over = len > MAXB;
    bit expOk = over || (modelEntries < NE && modelBeats >= nb);
    int id = nextId++;
    @(negedge clk);
    inValid = 1; inSop = 1; inEop = (nb == 1); inLen = LW'(len);
    inStation = 1'(st); inPort = PW'(port); inData = beatVal(id, 0);
    #1;
    chk(inReady == expOk, "R2", $sformatf("ready for %0dB start", len), BW'(inReady), BW'(expOk));
    if (!inReady) begin
      inValid = 0; inSop = 0; inEop = 0;
      return;
    end
    if (!over) begin
      modelBeats -= nb; modelEntries++;
      expId[st].push_back(id); expBeats[st].push_back(nb); expPort[st].push_back(port);
    end
    for (int b = 1; b < nb; b++) begin
      @(negedge clk);
      inSop = 0; inEop = (b == nb - 1); inData = beatVal(id, b);
    end
    @(negedge clk);
    inValid = 0; inSop = 0; inEop = 0;
  endtask

  task automatic drain(bit alwaysReady, output int cycles);
    int pos[2] = '{0, 0};
    cycles = 0;
    for (int c = 0; c < 5000 && (expId[0].size() != 0 || expId[1].size() != 0); c++) begin
      @(negedge clk);
      cycles++;
      for (int s = 0; s < 2; s++) deqReady[s] = alwaysReady || (($urandom % 4) != 0);
      #1;
      for (int s = 0; s < 2; s++) begin
        if (expId[s].size() != 0) begin
          int id = expId[s][0];
          int nb = expBeats[s][0];
          chk(deqValid[s] == 1'b1, "R4", $sformatf("valid with packet held st%0d", s), BW'(deqValid[s]), BW'(1));
          if (deqValid[s] && deqReady[s]) begin
            chk(deqData[s*BW +: BW] == beatVal(id, pos[s]), "R5", $sformatf("data st%0d", s),
                deqData[s*BW +: BW], beatVal(id, pos[s]));
            chk(deqSop[s] == (pos[s] == 0), "R5", "sop", BW'(deqSop[s]), BW'(pos[s] == 0));
            chk(deqEop[s] == (pos[s] == nb - 1), "R1", "eop at beat count", BW'(deqEop[s]), BW'(pos[s] == nb - 1));
            chk(int'(deqPort[s*PW +: PW]) == expPort[s][0], "R9", "port tag",
                BW'(deqPort[s*PW +: PW]), BW'(expPort[s][0]));
            if (pos[s] == nb - 1) begin
              void'(expId[s].pop_front()); void'(expBeats[s].pop_front()); void'(expPort[s].pop_front());
              modelBeats += nb; modelEntries--; pos[s] = 0;
            end else pos[s]++;
          end
        end else begin
          chk(deqValid[s] == 1'b0, "R9", $sformatf("no extra packet st%0d", s), BW'(deqValid[s]), BW'(0));
        end
      end
    end
    @(negedge clk);
    deqReady = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    summary();
    $finish;
  end

  initial begin
    int cyc;
    void'($urandom(32'h5eed_0a17));
    repeat (4) @(negedge clk);
    rstN = 1;
    #1;
    // R8: reset state
    chk(deqValid == 2'b00, "R8", "deqValid after reset", BW'(deqValid), BW'(0));
    chk(inReady == 1'b1, "R8", "inReady after reset", BW'(inReady), BW'(1));
    chk(entriesFull == 1'b0, "R8", "entriesFull after reset", BW'(entriesFull), BW'(0));
    chk(oversizeErr == 1'b0, "R8", "oversizeErr after reset", BW'(oversizeErr), BW'(0));

    // R1: beat counts at size boundaries, both stations (R9)
    sendPkt(12, 0, 1); sendPkt(276, 1, 2); sendPkt(20, 0, 3); sendPkt(21, 0, 0); sendPkt(41, 1, 3);
    drain(0, cyc);

    // R2: beat limit - 42 of 48 beats used, 7-beat refused, 6-beat fits, then 1-beat refused
    sendPkt(276, 0, 0); sendPkt(276, 0, 1); sendPkt(276, 1, 2);
    sendPkt(140, 1, 0); sendPkt(120, 0, 3); sendPkt(12, 1, 1);
    drain(0, cyc);

    // R3 / R6: fill all descriptors, one more refused, drain, refill
    for (int i = 0; i < NE; i++) sendPkt(12, i % 2, i % 4);
    chk(entriesFull == 1'b1, "R3", "full at 32 entries", BW'(entriesFull), BW'(1));
    sendPkt(12, 0, 0);
    drain(0, cyc);
    chk(entriesFull == 1'b0, "R3", "not full after drain", BW'(entriesFull), BW'(0));
    for (int i = 0; i < NE; i++) sendPkt(12, 1, 2);
    chk(entriesFull == 1'b1, "R6", "refill after release", BW'(entriesFull), BW'(1));
    drain(0, cyc);

    // R10: back-to-back drain, 2 x 3 beats in 6 cycles
    sendPkt(60, 0, 1); sendPkt(41, 0, 2);
    drain(1, cyc);
    chk(cyc == 6, "R10", "cycles for six beats", BW'(cyc), BW'(6));

    // R7: oversize dropped, sticky flag, next packet unaffected
    sendPkt(300, 1, 0);
    #1;
    chk(oversizeErr == 1'b1, "R7", "error flag set", BW'(oversizeErr), BW'(1));
    chk(deqValid == 2'b00, "R7", "nothing queued", BW'(deqValid), BW'(0));
    sendPkt(12, 1, 3);
    drain(0, cyc);
    chk(oversizeErr == 1'b1, "R7", "error flag sticky", BW'(oversizeErr), BW'(1));

    // Random rounds mixing all sizes, stations and ports
    for (int r = 0; r < 30; r++) begin
      int k = 1 + int'($urandom % 10);
      for (int p = 0; p < k; p++) begin
        int len = (($urandom % 8) == 0) ? 277 + int'($urandom % 100) : 1 + int'($urandom % MAXB);
        sendPkt(len, int'($urandom % 2), int'($urandom % 4));
      end
      drain(($urandom % 3) == 0, cyc);
    end

    summary();
    $finish;
  end
endmodule